// File: doc/BRIEF.md
# Frame Buffer Scan-Out Address Sequencer

This block produces the read addresses that stream a 512 x 256, one-byte-per-pixel picture out of a 128K-byte SRAM. It advances once per pixel clock. The host processor keeps control of line timing: it pulses the horizontal sync and writes the line (row) number into a register. The block supplies the nine low address bits from a column counter. The sync pulse resets that counter, and the counter then runs to the end of the line and stops there.

The same SRAM address and data pins carry host writes into video memory. A host write request is sampled on a pixel-clock edge and granted for exactly one pixel clock. During that cycle the scan-out address leaves the bus and the block drives the host's latched address and data with the write enable active. The pixel read strobe is withheld and the blank output goes high, so the screen shows black rather than corrupted data.

Blank also covers a porch of a few pixels at each end of the line. A row update that arrives inside the porch takes effect at once. One that arrives during visible pixels is parked and applied at the next sync.

Top module: `scanout_seq`

## Requirements
- R1: When no grant is active, `sram_addr_o` is the row in bits 16:9 and the column in bits 8:0.
- R2: A cycle with `hsync_i` high makes the column 0 in the next cycle. Without sync the column rises by one per clock, so a line reads columns 0 to 511 in order.
- R3: The column stops at 511, and blank stays high from there until the next sync.
- R4: Outside a grant, `blank_o` is high exactly when the column is below PORCH or at least 512 - PORCH (PORCH = 8 by default). `pix_stb_o` is the inverse of `blank_o` outside a grant.
- R5: A request sampled while no grant is active raises `hwr_gnt_o` for exactly one cycle, starting the next cycle. In that cycle `sram_we_n_o` is 0, `sram_dq_oe_o` is 1, and the address and data are the values sampled with the request.
- R6: While a grant is active, `sram_oe_n_o` is 1, `pix_stb_o` is 0 and `blank_o` is 1.
- R7: A row write made while the column is in the porch or unused region, or in the same cycle as a sync, appears in the row field in the next cycle.
- R8: A row write made during visible pixels leaves the row field unchanged until the next sync. The new row appears in the cycle after that sync.
- R9: During reset, `hwr_gnt_o` is 0, `sram_we_n_o` is 1, `sram_dq_oe_o` is 0, `blank_o` is 1 and `sram_ce_n_o` is 1. The chip enable goes active (0) from the first clock after reset.
- R10: Outside a grant, `sram_we_n_o` is 1, `sram_dq_oe_o` is 0 and `sram_oe_n_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| hsync_i | input | 1 | Host line sync; clears the column counter |
| row_wr_i | input | 1 | Row register write strobe |
| row_data_i | input | 8 | New row value |
| hwr_req_i | input | 1 | Host write request |
| hwr_addr_i | input | 17 | Host write address |
| hwr_data_i | input | 8 | Host write data |
| hwr_gnt_o | output | 1 | Host owns the SRAM bus this cycle |
| sram_addr_o | output | 17 | SRAM address |
| sram_ce_n_o | output | 1 | SRAM chip enable, active low |
| sram_oe_n_o | output | 1 | SRAM output enable, active low |
| sram_we_n_o | output | 1 | SRAM write enable, active low |
| sram_dq_o | output | 8 | Write data toward the SRAM |
| sram_dq_oe_o | output | 1 | Drive enable for `sram_dq_o` |
| pix_stb_o | output | 1 | Pixel data strobe for the DAC |
| blank_o | output | 1 | Blank to the DAC |

## Verification
The assertions check the following on every cycle:
- the one-cycle grant;
- that no read strobe or pixel strobe is given while the host owns the bus;
- the split of the address into row and column;
- the column stepping by one, clearing on sync and holding at 511;
- the porch blanking;
- a steady row field between syncs and row writes.

Some behaviour needs scenarios that the bench builds. These are the exact 0 to 511 address sequence of one line, and whether a row write is applied at once or deferred, depending on where in the line it lands. They also include writes that coincide with sync and back-to-back host requests, where the data bus must carry the sampled write data.

// File: rtl/scanout_pkg.sv
package scanout_pkg;
   typedef enum logic {
      ARB_IDLE  = 1'b0,
      ARB_WRITE = 1'b1
   } arb_state_e;
endpackage

// File: rtl/sq_col_counter.sv
module sq_col_counter #(
   parameter int unsigned COL_W = 9,
   parameter int unsigned PORCH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   output logic [COL_W-1:0] col_o,
   output logic             vblank_o
);
   localparam int unsigned      LINE = 2 ** COL_W;
   localparam logic [COL_W-1:0] LAST = COL_W'(LINE - 1);

   logic [COL_W-1:0] col_q;
   logic             past_end_q;
   logic             porch_blank;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q      <= LAST;
         past_end_q <= 1'b1;
      end else if (clr_i) begin
         col_q      <= '0;
         past_end_q <= 1'b0;
      end else if (col_q == LAST) begin
         past_end_q <= 1'b1;
      end else begin
         col_q <= col_q + 1'b1;
      end
   end

   generate
      if (PORCH == 0) begin : g_no_porch
         assign porch_blank = 1'b0;
      end else begin : g_porch
         localparam logic [COL_W-1:0] LO = COL_W'(PORCH);
         localparam logic [COL_W-1:0] HI = COL_W'(LINE - PORCH);
         assign porch_blank = (col_q < LO) || (col_q >= HI);
      end
   endgenerate

   assign col_o    = col_q;
   assign vblank_o = porch_blank | past_end_q;
endmodule

// File: rtl/sq_row_reg.sv
module sq_row_reg #(
   parameter int unsigned ROW_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [ROW_W-1:0] data_i,
   input  logic             sync_i,
   input  logic             vblank_i,
   output logic [ROW_W-1:0] row_o
);
   logic [ROW_W-1:0] row_q;
   logic [ROW_W-1:0] shadow_q;
   logic             pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q    <= '0;
         shadow_q <= '0;
         pend_q   <= 1'b0;
      end else if (wr_i) begin
         if (sync_i || vblank_i) begin
            row_q  <= data_i;
            pend_q <= 1'b0;
         end else begin
            shadow_q <= data_i;
            pend_q   <= 1'b1;
         end
      end else if (sync_i && pend_q) begin
         row_q  <= shadow_q;
         pend_q <= 1'b0;
      end
   end

   assign row_o = row_q;
endmodule

// File: rtl/sq_host_arb.sv
module sq_host_arb
   import scanout_pkg::*;
#(
   parameter int unsigned ADDR_W = 17,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              gnt_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o
);
   arb_state_e        state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ARB_IDLE;
         addr_q  <= '0;
         data_q  <= '0;
      end else begin
         case (state_q)
            ARB_IDLE: begin
               if (req_i) begin
                  state_q <= ARB_WRITE;
                  addr_q  <= addr_i;
                  data_q  <= data_i;
               end
            end
            default: state_q <= ARB_IDLE;
         endcase
      end
   end

   assign gnt_o  = (state_q == ARB_WRITE);
   assign addr_o = addr_q;
   assign data_o = data_q;
endmodule

// File: rtl/scanout_seq.sv
module scanout_seq #(
   parameter int unsigned COL_W  = 9,
   parameter int unsigned ROW_W  = 8,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned PORCH  = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   hsync_i,
   input  logic                   row_wr_i,
   input  logic [ROW_W-1:0]       row_data_i,
   input  logic                   hwr_req_i,
   input  logic [ROW_W+COL_W-1:0] hwr_addr_i,
   input  logic [DATA_W-1:0]      hwr_data_i,
   output logic                   hwr_gnt_o,
   output logic [ROW_W+COL_W-1:0] sram_addr_o,
   output logic                   sram_ce_n_o,
   output logic                   sram_oe_n_o,
   output logic                   sram_we_n_o,
   output logic [DATA_W-1:0]      sram_dq_o,
   output logic                   sram_dq_oe_o,
   output logic                   pix_stb_o,
   output logic                   blank_o
);
   localparam int unsigned ADDR_W = ROW_W + COL_W;

   initial begin
      if (COL_W < 2 || ROW_W < 1 || DATA_W < 1)
         $fatal(1, "scanout_seq: widths too small");
      if (2 * PORCH >= 2 ** COL_W)
         $fatal(1, "scanout_seq: porch leaves no visible pixels");
   end

   logic [COL_W-1:0]  col;
   logic              vblank;
   logic [ROW_W-1:0]  row;
   logic              gnt;
   logic [ADDR_W-1:0] host_addr;
   logic [DATA_W-1:0] host_data;
   logic              live_q;

   sq_col_counter #(.COL_W(COL_W), .PORCH(PORCH)) u_col (
      .clk(clk), .rst_n(rst_n), .clr_i(hsync_i),
      .col_o(col), .vblank_o(vblank)
   );

   sq_row_reg #(.ROW_W(ROW_W)) u_row (
      .clk(clk), .rst_n(rst_n), .wr_i(row_wr_i), .data_i(row_data_i),
      .sync_i(hsync_i), .vblank_i(vblank), .row_o(row)
   );

   sq_host_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .req_i(hwr_req_i), .addr_i(hwr_addr_i),
      .data_i(hwr_data_i), .gnt_o(gnt), .addr_o(host_addr), .data_o(host_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= 1'b0;
      else        live_q <= 1'b1;
   end

   assign hwr_gnt_o    = gnt;
   assign sram_addr_o  = gnt ? host_addr : {row, col};
   assign sram_ce_n_o  = ~live_q;
   assign sram_oe_n_o  = gnt;
   assign sram_we_n_o  = ~gnt;
   assign sram_dq_o    = host_data;
   assign sram_dq_oe_o = gnt;
   assign pix_stb_o    = ~gnt & ~vblank;
   assign blank_o      = gnt | vblank;
endmodule

// File: rtl/scanout_seq_checker.sv
module scanout_seq_checker #(
   parameter int unsigned COL_W = 9,
   parameter int unsigned ROW_W = 8,
   parameter int unsigned PORCH = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   hsync_i,
   input logic                   row_wr_i,
   input logic                   hwr_gnt_o,
   input logic [ROW_W+COL_W-1:0] sram_addr_o,
   input logic                   sram_oe_n_o,
   input logic                   sram_we_n_o,
   input logic                   sram_dq_oe_o,
   input logic                   pix_stb_o,
   input logic                   blank_o
);
   localparam int unsigned      LINE = 2 ** COL_W;
   localparam logic [COL_W-1:0] LAST = COL_W'(LINE - 1);
   localparam logic [COL_W-1:0] LO   = COL_W'(PORCH);
   localparam logic [COL_W-1:0] HI   = COL_W'(LINE - PORCH);
   localparam logic [COL_W-1:0] ONE  = COL_W'(1);

   logic [COL_W-1:0] col;
   logic [ROW_W-1:0] row;
   assign col = sram_addr_o[COL_W-1:0];
   assign row = sram_addr_o[ROW_W+COL_W-1:COL_W];

   AST_GNT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      hwr_gnt_o |=> !hwr_gnt_o); // R5
   AST_GNT_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      hwr_gnt_o |-> (!sram_we_n_o && sram_dq_oe_o)); // R5
   AST_NO_READ_IN_GNT: assert property (@(posedge clk) disable iff (!rst_n)
      hwr_gnt_o |-> (sram_oe_n_o && !pix_stb_o && blank_o)); // R6
   AST_IDLE_READS: assert property (@(posedge clk) disable iff (!rst_n)
      !hwr_gnt_o |-> (sram_we_n_o && !sram_dq_oe_o && !sram_oe_n_o)); // R10
   AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (!hwr_gnt_o && $past(hsync_i)) |-> (col == '0)); // R2
   AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!hwr_gnt_o && !$past(hwr_gnt_o) && !$past(hsync_i) && $past(col) != LAST)
      |-> (col == $past(col) + ONE)); // R2
   AST_COL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!hwr_gnt_o && !$past(hwr_gnt_o) && !$past(hsync_i) && $past(col) == LAST)
      |-> (col == LAST && blank_o)); // R3
   AST_PORCH_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      !hwr_gnt_o |-> (blank_o == ((col < LO) || (col >= HI)) && pix_stb_o == !blank_o)); // R4
   AST_ROW_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (!hwr_gnt_o && !$past(hwr_gnt_o) && !$past(hsync_i) && !$past(row_wr_i))
      |-> (row == $past(row))); // R8
endmodule

bind scanout_seq scanout_seq_checker #(.COL_W(COL_W), .ROW_W(ROW_W), .PORCH(PORCH)) u_chk (
   .clk(clk), .rst_n(rst_n), .hsync_i(hsync_i), .row_wr_i(row_wr_i),
   .hwr_gnt_o(hwr_gnt_o), .sram_addr_o(sram_addr_o), .sram_oe_n_o(sram_oe_n_o),
   .sram_we_n_o(sram_we_n_o), .sram_dq_oe_o(sram_dq_oe_o),
   .pix_stb_o(pix_stb_o), .blank_o(blank_o)
);

// File: tb/scanout_seq_test.sv
module scanout_seq_test;
   localparam int PORCH = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hsync = 1'b0, row_wr = 1'b0, req = 1'b0;
   logic [7:0]  row_data = '0, hdata = '0;
   logic [16:0] haddr = '0;
   logic        gnt, ce_n, oe_n, we_n, dq_oe, pix_stb, blank;
   logic [16:0] addr;
   logic [7:0]  dq;

   int compared = 0, mismatched = 0;

   // model state
   int         m_col;
   logic [7:0] m_row, m_shad, m_ld;
   logic       m_pend, m_gnt, m_live;
   logic [16:0] m_la;

   always #2.5 clk = ~clk;

   scanout_seq uut (
      .clk(clk), .rst_n(rst_n), .hsync_i(hsync), .row_wr_i(row_wr),
      .row_data_i(row_data), .hwr_req_i(req), .hwr_addr_i(haddr),
      .hwr_data_i(hdata), .hwr_gnt_o(gnt), .sram_addr_o(addr),
      .sram_ce_n_o(ce_n), .sram_oe_n_o(oe_n), .sram_we_n_o(we_n),
      .sram_dq_o(dq), .sram_dq_oe_o(dq_oe), .pix_stb_o(pix_stb), .blank_o(blank)
   );

   function automatic logic porch_of(int c);
      return (c < PORCH) || (c >= 512 - PORCH);
   endfunction

   task automatic check(string req_tag, logic [31:0] act, logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s at %0t: actual %0h expected %0h", req_tag, $time, act, exp);
      end
   endtask

   task automatic compare_all();
      logic vb;
      vb = porch_of(m_col);
      check("R5 gnt", 32'(gnt), 32'(m_gnt));
      check("R1 addr", 32'(addr), m_gnt ? 32'(m_la) : 32'({m_row, 9'(m_col)}));
      check("R6 oe_n", 32'(oe_n), 32'(m_gnt));
      check("R10 we_n", 32'(we_n), 32'(!m_gnt));
      check("R5 dq_oe", 32'(dq_oe), 32'(m_gnt));
      if (m_gnt) check("R5 dq", 32'(dq), 32'(m_ld));
      check("R4 blank", 32'(blank), 32'(m_gnt || vb));
      check("R6 pix_stb", 32'(pix_stb), 32'(!m_gnt && !vb));
      check("R9 ce_n", 32'(ce_n), 32'(!m_live));
   endtask

   task automatic update_model();
      logic vb;
      vb = porch_of(m_col);
      if (row_wr) begin
         if (hsync || vb) begin m_row = row_data; m_pend = 1'b0; end
         else begin m_shad = row_data; m_pend = 1'b1; end
      end else if (hsync && m_pend) begin
         m_row = m_shad; m_pend = 1'b0;
      end
      if (hsync) m_col = 0;
      else if (m_col != 511) m_col = m_col + 1;
      if (m_gnt) m_gnt = 1'b0;
      else if (req) begin m_gnt = 1'b1; m_la = haddr; m_ld = hdata; end
      m_live = 1'b1;
   endtask

   // called at a negedge: drive inputs, clock once, compare at next negedge
   task automatic step(logic hs, logic rw, logic [7:0] rd, logic rq,
                       logic [16:0] ra, logic [7:0] dd);
      hsync = hs; row_wr = rw; row_data = rd; req = rq; haddr = ra; hdata = dd;
      @(posedge clk);
      update_model();
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 0, 8'h00, 0, '0, '0);
   endtask

   initial begin
      #(200000 * 5);
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      int line_len, line_pos;
      void'($urandom(32'd20240611));
      m_col = 511; m_row = '0; m_shad = '0; m_pend = 1'b0; m_gnt = 1'b0;
      m_live = 1'b0; m_la = '0; m_ld = '0;

      // R9: reset state
      repeat (3) @(negedge clk);
      check("R9 gnt", 32'(gnt), 0);
      check("R9 we_n", 32'(we_n), 1);
      check("R9 dq_oe", 32'(dq_oe), 0);
      check("R9 blank", 32'(blank), 1);
      check("R9 ce_n", 32'(ce_n), 1);
      rst_n = 1'b1;
      step(0, 0, 8'h00, 0, '0, '0);
      check("R9 ce_n active", 32'(ce_n), 0);

      // R7: row write while saturated (blank) applies next cycle
      step(0, 1, 8'h3C, 0, '0, '0);
      check("R7 row immediate", 32'(addr[16:9]), 32'h3C);

      // R2: one full line, columns 0..511 in order
      step(1, 0, 8'h00, 0, '0, '0);
      for (int k = 0; k < 512; k++) begin
         check("R2 line address", 32'(addr), 32'({8'h3C, 9'(k)}));
         if (k < 511) step(0, 0, 8'h00, 0, '0, '0);
      end
      // R3: saturation and blank hold
      idle(6);
      check("R3 col held", 32'(addr[8:0]), 32'd511);
      check("R3 blank held", 32'(blank), 1);

      // R8: write during active video is deferred to next sync
      step(1, 0, 8'h00, 0, '0, '0);
      idle(100);
      step(0, 1, 8'h5A, 0, '0, '0);
      check("R8 row unchanged", 32'(addr[16:9]), 32'h3C);
      idle(20);
      check("R8 row still old", 32'(addr[16:9]), 32'h3C);
      step(1, 0, 8'h00, 0, '0, '0);
      check("R8 row after sync", 32'(addr[16:9]), 32'h5A);
      check("R2 col after sync", 32'(addr[8:0]), 0);

      // R4: porch edges
      idle(7);
      check("R4 col7 blank", 32'(blank), 1);
      step(0, 0, 8'h00, 0, '0, '0);
      check("R4 col8 visible", 32'(blank), 0);

      // R5/R6: host write in active video
      idle(50);
      step(0, 0, 8'h00, 1, 17'h1ABCD, 8'hE7);
      check("R5 grant", 32'(gnt), 1);
      check("R5 addr", 32'(addr), 32'h1ABCD);
      check("R5 data", 32'(dq), 32'hE7);
      check("R6 no read", 32'(oe_n), 1);
      check("R6 blank", 32'(blank), 1);
      step(0, 0, 8'h00, 0, '0, '0);
      check("R5 grant ends", 32'(gnt), 0);
      check("R10 read resumes", 32'(oe_n), 0);
      // back-to-back request held high
      step(0, 0, 8'h00, 1, 17'h00011, 8'h11);
      step(0, 0, 8'h00, 1, 17'h00022, 8'h22);
      step(0, 0, 8'h00, 1, 17'h00033, 8'h33);
      check("R5 second grant data", 32'(dq), 32'h33);
      step(0, 0, 8'h00, 0, '0, '0);
      // R7: row write coincident with sync applies immediately
      idle(30);
      step(1, 1, 8'h77, 0, '0, '0);
      check("R7 row with sync", 32'(addr[16:9]), 32'h77);

      // random phase
      line_len = 520; line_pos = 0;
      for (int n = 0; n < 30000; n++) begin
         logic hs;
         hs = (line_pos >= line_len);
         if (hs) begin line_pos = 0; line_len = 512 + int'($urandom_range(30)); end
         else line_pos++;
         step(hs, ($urandom_range(149) == 0), 8'($urandom), ($urandom_range(24) == 0),
              17'($urandom), 8'($urandom));
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule